// File: doc/BRIEF.md
# Packed-BCD Decimal Adjust Unit

This unit corrects an accumulator value that came out of a plain binary addition of two packed-BCD operands. It takes the raw sum, the carry flag and the half-carry flag left by that addition. It adds a correction of 00h, 06h, 60h or 66h to the value, so that each 4-bit digit ends up as a valid decimal digit.

It returns the corrected byte and a fresh set of flags: carry, half-carry, sign, zero and parity. The caller pulses `start_i` for one cycle with the operands present. On the next clock edge the corrected value and flags are registered, and `done_o` pulses for one cycle. The outputs keep their values until the next start.

The number of digits is a parameter (two by default). The least significant digit is forced by the incoming half-carry, and the most significant digit is forced by the incoming carry. Any digit in between is corrected only when it exceeds nine. Any correction of a digit ripples a carry into the digit above it. The unit assumes that its input is the result of an addition. It does not perform decimal subtraction.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While reset is high and after reset until the first start, `acc_o`, `cy_o`, `ac_o`, `sign_o`, `zero_o`, `parity_o` and `done_o` are all 0.
- R2: Least significant digit: when the input nibble is greater than 9 or `ac_i` is 1, 6 is added to that nibble, and any carry out of it ripples into the next digit. Otherwise the nibble is passed through unchanged.
- R3: Most significant digit: this step uses the value after the ripple from below. If that value is greater than 9, or if `cy_i` is 1, or if the ripple wrapped the digit from F to 0, 6 is added to it and `cy_o` becomes 1. Otherwise the digit is unchanged and `cy_o` becomes 0 (for example 7Dh→83h, EBh→51h with carry, 21h with both flags→87h with carry, A5h→05h with carry).
- R4: When `cy_i` is 1 at start, `cy_o` is 1 after the adjustment.
- R5: `ac_o` equals the carry out of the correction of the least significant digit.
- R6: `sign_o` is the top bit of `acc_o`. `zero_o` is 1 exactly when `acc_o` is zero. `parity_o` is 1 exactly when `acc_o` holds an even number of ones.
- R7: `done_o` is 1 in the cycle after every cycle in which `start_i` is 1, and 0 otherwise. The new results are visible in the same cycle as `done_o`. Starts on consecutive cycles each produce their own result.
- R8: Without `start_i`, `acc_o` and all flag outputs hold their values, whatever the data inputs do.
- R9: An input whose digits are all 9 or less, with `cy_i` and `ac_i` both 0, is returned unchanged, with `cy_o` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to adjust the present inputs |
| acc_i | input | 4*DIGITS (8) | Raw binary sum to correct |
| cy_i | input | 1 | Carry flag left by the addition |
| ac_i | input | 1 | Half-carry flag left by the addition |
| acc_o | output | 4*DIGITS (8) | Corrected packed-BCD value |
| cy_o | output | 1 | Carry after adjustment |
| ac_o | output | 1 | Carry out of the low-digit correction |
| sign_o | output | 1 | Top bit of the corrected value |
| zero_o | output | 1 | Corrected value is zero |
| parity_o | output | 1 | Corrected value has even parity |
| done_o | output | 1 | Result registered this cycle |

## Verification
The risky overlap is a ripple from the low-digit correction that lands in the same evaluation as the high-digit decision. For example, FAh wraps the high digit from F to 0, and that carry alone must force the second correction. Likewise, 9Ah pushes the high digit to Ah, and that value must then be corrected too. The bench provokes these cases directly and also sweeps every byte under all four flag combinations. Each result is compared with a digit-by-digit model written from the requirements.

A second overlap is a new `start_i` arriving in the same cycle as the previous `done_o`. Back-to-back starts are judged by checking that each registered result belongs to its own request.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int NIB_W     = 4;
  localparam int DIGIT_MAX = 9;
  localparam int FIX_VAL   = 6;

  // true when every packed digit of v is a legal decimal digit
  function automatic logic digits_valid(input logic [63:0] v, input int ndig);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < ndig; k++) begin
      if (v[k*NIB_W +: NIB_W] > NIB_W'(DIGIT_MAX)) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/bcd_digit_fix.sv
module bcd_digit_fix
  import bcd_adj_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  logic [W-1:0] nib_i,
  input  logic         cin_i,
  input  logic         force_i,
  output logic [W-1:0] nib_o,
  output logic         cout_o
);
  localparam logic [W:0] FIX = (W+1)'(FIX_VAL);
  localparam logic [W-1:0] LIM = W'(DIGIT_MAX);

  logic [W:0] rippled;
  logic [W:0] fixed;
  logic       need_fix;

  always_comb begin
    rippled  = {1'b0, nib_i} + {{W{1'b0}}, cin_i};
    need_fix = force_i | rippled[W] | (rippled[W-1:0] > LIM);
    fixed    = {1'b0, rippled[W-1:0]} + (need_fix ? FIX : '0);
    nib_o    = fixed[W-1:0];
    cout_o   = rippled[W] | fixed[W];
  end
endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  output logic         sign_o,
  output logic         zero_o,
  output logic         parity_o
);
  always_comb begin
    sign_o   = val_i[W-1];
    zero_o   = (val_i == '0);
    parity_o = ~(^val_i);
  end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [NIB_W*DIGITS-1:0] acc_i,
  input  logic                    cy_i,
  input  logic                    ac_i,
  output logic [NIB_W*DIGITS-1:0] acc_o,
  output logic                    cy_o,
  output logic                    ac_o,
  output logic                    sign_o,
  output logic                    zero_o,
  output logic                    parity_o,
  output logic                    done_o
);
  localparam int W = NIB_W * DIGITS;

  logic [DIGITS:0] chain;
  logic [W-1:0]    adj_val;
  logic            adj_cy;
  logic            s_nxt, z_nxt, p_nxt;

  assign chain[0] = 1'b0;

  // digit chain: low digit forced by half-carry, top digit by carry
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    localparam bit IS_LOW = (g == 0);
    localparam bit IS_TOP = (g == DIGITS - 1);
    logic frc;
    assign frc = (IS_LOW ? ac_i : 1'b0) | (IS_TOP ? cy_i : 1'b0);
    bcd_digit_fix #(.W(NIB_W)) u_fix (
      .nib_i   (acc_i[g*NIB_W +: NIB_W]),
      .cin_i   (chain[g]),
      .force_i (frc),
      .nib_o   (adj_val[g*NIB_W +: NIB_W]),
      .cout_o  (chain[g+1])
    );
  end

  // an incoming carry always forces the top digit, so carry stays set
  assign adj_cy = chain[DIGITS] | cy_i;

  bcd_flag_gen #(.W(W)) u_flags (
    .val_i    (adj_val),
    .sign_o   (s_nxt),
    .zero_o   (z_nxt),
    .parity_o (p_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o    <= '0;
      cy_o     <= 1'b0;
      ac_o     <= 1'b0;
      sign_o   <= 1'b0;
      zero_o   <= 1'b0;
      parity_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        acc_o    <= adj_val;
        cy_o     <= adj_cy;
        ac_o     <= chain[1];
        sign_o   <= s_nxt;
        zero_o   <= z_nxt;
        parity_o <= p_nxt;
      end
    end
  end

  // R7
  done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> done_o);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !done_o);
  // R4
  carry_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && cy_i) |=> cy_o);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> ($stable(acc_o) && $stable(cy_o) && $stable(ac_o)));
  // R9
  clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !cy_i && !ac_i && digits_valid(64'(acc_i), DIGITS))
      |=> (acc_o == $past(acc_i) && !cy_o));
  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (zero_o == (acc_o == '0)));
  // R6
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (sign_o == acc_o[W-1]));
endmodule

// File: tb/bcd_adjust_unit_tb.sv
module bcd_adjust_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] acc_i = '0;
  logic       cy_i = 1'b0;
  logic       ac_i = 1'b0;
  logic [7:0] acc_o;
  logic       cy_o, ac_o, sign_o, zero_o, parity_o, done_o;

  int n_chk = 0;
  int n_fail = 0;

  bcd_adjust_unit u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .acc_i(acc_i), .cy_i(cy_i),
    .ac_i(ac_i), .acc_o(acc_o), .cy_o(cy_o), .ac_o(ac_o), .sign_o(sign_o),
    .zero_o(zero_o), .parity_o(parity_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // model: returns {acc[7:0], cy, ac}
  function automatic logic [9:0] model(input logic [7:0] a, input logic c, input logic h);
    logic [4:0] lo, hi;
    logic       carry, half;
    lo = {1'b0, a[3:0]};
    half = 1'b0;
    if (lo > 9 || h) begin
      lo = lo + 5'd6;
      half = lo[4];
    end
    hi = {1'b0, a[7:4]} + {4'b0, half};
    carry = c | hi[4];
    hi[4] = 1'b0;
    if (hi > 9 || carry) begin
      hi = hi + 5'd6;
      carry = 1'b1;
    end else carry = 1'b0;
    return {hi[3:0], lo[3:0], carry, half};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input logic [7:0] a, input logic c, input logic h, input string req);
    logic [9:0] m;
    m = model(a, c, h);
    check(acc_o == m[9:2], req, "acc", acc_o, m[9:2]);
    check(cy_o == m[1], req, "cy", cy_o, m[1]);
    check(ac_o == m[0], "R5", "ac", ac_o, m[0]);
    check(sign_o == m[9], "R6", "sign", sign_o, m[9]);
    check(zero_o == (m[9:2] == 0), "R6", "zero", zero_o, m[9:2] == 0);
    check(parity_o == ~^m[9:2], "R6", "parity", parity_o, ~^m[9:2]);
    check(done_o == 1'b1, "R7", "done", done_o, 1);
  endtask

  task automatic run_adj(input logic [7:0] a, input logic c, input logic h, input string req);
    @(negedge clk);
    acc_i = a; cy_i = c; ac_i = h; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    compare(a, c, h, req);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(acc_o == 0 && cy_o == 0 && ac_o == 0, "R1", "data", {acc_o, cy_o, ac_o}, 0);
    check(sign_o == 0 && zero_o == 0 && parity_o == 0 && done_o == 0, "R1", "flags",
          {sign_o, zero_o, parity_o, done_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(acc_o == 0 && done_o == 0, "R1", "after release", {acc_o, done_o}, 0);
  endtask

  task automatic t_examples;
    // R3 fixed cases
    run_adj(8'h7D, 0, 0, "R2");  check(acc_o == 8'h83 && !cy_o, "R3", "7D", {acc_o, cy_o}, 9'h106);
    run_adj(8'hEB, 0, 0, "R3");  check(acc_o == 8'h51 && cy_o, "R3", "EB", {acc_o, cy_o}, 9'h0A3);
    run_adj(8'h21, 1, 1, "R3");  check(acc_o == 8'h87 && cy_o, "R3", "21", {acc_o, cy_o}, 9'h10F);
    run_adj(8'hA5, 0, 0, "R3");  check(acc_o == 8'h05 && cy_o, "R3", "A5", {acc_o, cy_o}, 9'h00B);
    // ripple wraps F to 0, ripple pushes 9 to A
    run_adj(8'hFA, 0, 0, "R3");  check(acc_o == 8'h60 && cy_o, "R3", "FA", {acc_o, cy_o}, 9'h0C1);
    run_adj(8'h9A, 0, 0, "R3");  check(acc_o == 8'h00 && cy_o && zero_o, "R6", "9A", {acc_o, cy_o}, 9'h001);
    // R2 half-carry alone forces low correction
    run_adj(8'h12, 0, 1, "R2");  check(acc_o == 8'h18 && !ac_o, "R2", "12 ac", acc_o, 8'h18);
  endtask

  task automatic t_clean;
    // R9
    run_adj(8'h89, 0, 0, "R9");  check(acc_o == 8'h89 && !cy_o, "R9", "89", {acc_o, cy_o}, 9'h112);
    run_adj(8'h00, 0, 0, "R9");  check(acc_o == 8'h00 && zero_o && parity_o, "R9", "00", acc_o, 0);
  endtask

  task automatic t_carry_in;
    // R4 carry in stays set for every value
    for (int v = 0; v < 256; v += 17) begin
      run_adj(8'(v), 1, v[0], "R4");
      check(cy_o == 1'b1, "R4", "cy kept", cy_o, 1);
    end
  endtask

  task automatic t_hold;
    logic [7:0] keep;
    run_adj(8'h47, 0, 0, "R8");
    keep = acc_o;
    @(negedge clk);
    check(done_o == 1'b0, "R7", "done one cycle", done_o, 0);
    acc_i = 8'hFF; cy_i = 1; ac_i = 1;
    repeat (3) @(negedge clk);
    check(acc_o == keep && !cy_o, "R8", "hold", acc_o, keep);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    acc_i = 8'h3C; cy_i = 0; ac_i = 0; start_i = 1'b1;
    @(negedge clk);
    acc_i = 8'hB7; cy_i = 0; ac_i = 1;
    compare(8'h3C, 0, 0, "R7");
    @(negedge clk);
    start_i = 1'b0;
    compare(8'hB7, 0, 1, "R7");
    @(negedge clk);
    check(done_o == 1'b0, "R7", "done drop", done_o, 0);
  endtask

  task automatic t_sweep;
    for (int v = 0; v < 1024; v++) begin
      run_adj(8'(v), v[8], v[9], "R2 R3");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_examples();
    t_clean();
    t_carry_in();
    t_hold();
    t_back_to_back();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule